// File: doc/BRIEF.md
# Command-Driven NOR Flash Model

This block is a synchronous simulation model of a parallel NOR flash that accepts the common two-cycle command set. It is driven by a simple bus slave port. The port carries a byte address, write data at the device width, a write strobe and a read strobe. Read data is registered and appears on the clock after the read strobe. The storage is a small word array split into uniform erase sectors.

Every bus write is a command cycle. The low byte of the write data is the command code. The block tracks a mode, and the mode decides two things: what the next write means and what a read returns. A read can return array data, the 8-bit status register or a byte of the query table. An erase runs over several clocks. While it runs, status bit 7 (the ready flag) reads as 0.

The model is meant to sit behind a bus fabric in a system-level simulation. There it stands in for a boot flash, so software-style drivers for program, erase, lock and query can run against it. In the default configuration the device is 16 bits wide, with 4 sectors of 16 bytes each.

Top module: `nor_cmd_flash`

## Requirements
- R1: After reset the block is in read-array mode, the status register is 0x00, and every storage word reads as all ones.
- R2: The read strobe captures a result into rdata at the next clock edge, and rdata holds its value in cycles without a read. In read-array mode the result is the word at index addr >> log2(DATA_W/8).
- R3: Writing 0x70 from read-array or status mode selects status mode. There, reads return the status byte zero-extended, and writing 0xFF returns to read-array mode.
- R4: Writing 0x50 from read-array or status mode clears the status register to 0x00 and selects read-array mode.
- R5: Buffered program starts with 0xE8. The next write's low byte is a count N. The following N+1 writes each store their full data word at their address and set status bit 7. Then one more write ends the sequence and returns to read-array mode.
- R6: The write that follows the last of the N+1 data writes is taken as the confirm cycle (0xD0 expected) and is never stored into the array.
- R7: Writing 0x20 and then 0xD0 erases the sector that holds the second write's address, setting all its words to all ones. Other sectors are left untouched. Status bit 7 reads 0 from the confirm until the erase ends. It is then set, and the block stays in status mode.
- R8: After 0x20, a second write of any value other than 0xD0 (0xFF included) returns to read-array mode without erasing anything.
- R9: After 0x60, a second write of 0xD0 or 0x01 sets status bit 7 and returns to read-array mode. Any other value returns to read-array mode and leaves the status unchanged.
- R10: Writing 0x98 enters query mode. There, reads return the table byte at index addr >> log2(DATA_W/8). The table holds 0x51, 0x52, 0x59 at 0x10..0x12, 0x01 at 0x13, 0x00 at 0x14, log2(total bytes) at 0x27, 0x01 at 0x2C, sectors−1 at 0x2D, and 0 elsewhere, with any index of 0x40 or above reading 0. Only 0xFF leaves query mode, and other writes are ignored.
- R11: An unrecognised command code written in read-array or status mode selects read-array mode.
- R12: Writes that arrive while an erase is running are ignored.
- R13: While the block waits for an erase or lock second cycle, or is anywhere in the buffered-program sequence, reads return the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | DATA_W | Write data; the low byte is the command code |
| wr | input | 1 | Write strobe (one command cycle per clock) |
| rd | input | 1 | Read strobe |
| rdata | output | DATA_W | Registered read result |

## Verification
The bench sweeps every word after a full-array program and again after a sector erase. A wrong sector mask would wipe or miss words, and a wrong word shift would alias addresses. Count handling is checked with a count of zero, where an off-by-one design either stores the confirm cycle as data or drops the single data word. Status must read 0 in the first clocks of an erase and read ready afterwards. A write of 0xFF during the erase must not pull the block out of status mode, because a design that failed to ignore it would return array data instead. The whole query window is swept, including indices past the table, and aborted erase and lock sequences are checked to leave data and status unchanged.

// File: rtl/nor_cmd_flash.sv
module nor_cmd_flash #(
  parameter int DATA_W       = 16,
  parameter int SECTOR_BYTES = 16,
  parameter int NUM_SECTORS  = 4,
  parameter int ADDR_W       = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata
);
  localparam int NB       = DATA_W / 8;
  localparam int SH       = $clog2(NB);
  localparam int TOTAL    = SECTOR_BYTES * NUM_SECTORS;
  localparam int WORDS    = TOTAL / NB;
  localparam int WPS      = SECTOR_BYTES / NB;
  localparam int WI_W     = $clog2(WORDS);
  localparam int WP_W     = $clog2(WPS);
  localparam int SI_W     = $clog2(NUM_SECTORS);
  localparam int SIZE_LOG = $clog2(TOTAL);
  localparam int QLEN     = 64;

  typedef enum logic [3:0] {
    M_ARRAY = 4'd0, M_STATUS = 4'd1, M_QUERY = 4'd2, M_ERASE_CF = 4'd3,
    M_ERASING = 4'd4, M_LOCK_CF = 4'd5, M_WB_CNT = 4'd6, M_WB_DATA = 4'd7,
    M_WB_CF = 4'd8
  } mode_t;

  mode_t             mode;
  logic [7:0]        status;
  logic [7:0]        cnt;
  logic [SI_W-1:0]   er_sec;
  logic [WP_W-1:0]   er_ptr;
  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] rd_mux;

  wire [7:0]        cmd  = wdata[7:0];
  wire [WI_W-1:0]   widx = addr[SH +: WI_W];
  wire [ADDR_W-1:0] qidx = addr >> SH;

  function automatic logic [7:0] qbyte(input logic [ADDR_W-1:0] i);
    if (int'(i) >= QLEN) return 8'h00;
    case (int'(i))
      16:      return 8'h51;
      17:      return 8'h52;
      18:      return 8'h59;
      19:      return 8'h01;
      39:      return 8'(SIZE_LOG);
      44:      return 8'h01;
      45:      return 8'(NUM_SECTORS - 1);
      default: return 8'h00;
    endcase
  endfunction

  always_comb begin
    case (mode)
      M_ARRAY: rd_mux = mem[widx];
      M_QUERY: rd_mux = DATA_W'(qbyte(qidx));
      default: rd_mux = DATA_W'(status);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= M_ARRAY;
      status <= 8'h00;
      cnt    <= 8'h00;
      er_sec <= '0;
      er_ptr <= '0;
      rdata  <= '0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      if (rd) rdata <= rd_mux;
      if (mode == M_ERASING) begin
        mem[{er_sec, er_ptr}] <= '1;
        er_ptr <= er_ptr + 1'b1;
        if (er_ptr == WP_W'(WPS - 1)) begin
          status[7] <= 1'b1;
          mode      <= M_STATUS;
        end
      end else if (wr) begin
        case (mode)
          M_ARRAY, M_STATUS: begin
            case (cmd)
              8'h70: mode <= M_STATUS;
              8'h50: begin status <= 8'h00; mode <= M_ARRAY; end
              8'h20: mode <= M_ERASE_CF;
              8'h60: mode <= M_LOCK_CF;
              8'h98: mode <= M_QUERY;
              8'hE8: mode <= M_WB_CNT;
              default: mode <= M_ARRAY;
            endcase
          end
          M_QUERY: if (cmd == 8'hFF) mode <= M_ARRAY;
          M_ERASE_CF: begin
            if (cmd == 8'hD0) begin
              er_sec    <= addr[SH+WP_W +: SI_W];
              er_ptr    <= '0;
              status[7] <= 1'b0;
              mode      <= M_ERASING;
            end else mode <= M_ARRAY;
          end
          M_LOCK_CF: begin
            if (cmd == 8'hD0 || cmd == 8'h01) status[7] <= 1'b1;
            mode <= M_ARRAY;
          end
          M_WB_CNT: begin
            cnt  <= cmd;
            mode <= M_WB_DATA;
          end
          M_WB_DATA: begin
            mem[widx] <= wdata;
            status[7] <= 1'b1;
            if (cnt == 8'h00) mode <= M_WB_CF;
            else cnt <= cnt - 8'h01;
          end
          default: mode <= M_ARRAY;
        endcase
      end
    end
  end
endmodule

module nor_cmd_flash_chk #(
  parameter int DATA_W = 16
)(
  input logic              clk,
  input logic              rst_n,
  input logic              wr,
  input logic              rd,
  input logic [7:0]        cmd,
  input logic [DATA_W-1:0] rdata,
  input logic [3:0]        mode_q,
  input logic [7:0]        st
);
  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));

  // R4
  clear_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (mode_q == 4'd0 || mode_q == 4'd1) && cmd == 8'h50) |=> (st == 8'h00 && mode_q == 4'd0));

  // R7
  erase_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && mode_q == 4'd3 && cmd == 8'hD0) |=> (mode_q == 4'd4 && !st[7]));

  // R7
  erase_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 4'd4) |=> ((mode_q == 4'd4 && !st[7]) || (mode_q == 4'd1 && st[7])));

  // R5
  program_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && mode_q == 4'd7) |=> st[7]);

  // R10
  query_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && mode_q == 4'd2 && cmd == 8'hFF) |=> (mode_q == 4'd0));

  // R10
  query_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && mode_q == 4'd2 && cmd != 8'hFF) |=> (mode_q == 4'd2));

  // R9
  lock_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && mode_q == 4'd5) |=> (mode_q == 4'd0));
endmodule

bind nor_cmd_flash nor_cmd_flash_chk #(.DATA_W(DATA_W)) chk (
  .clk(clk), .rst_n(rst_n), .wr(wr), .rd(rd), .cmd(cmd),
  .rdata(rdata), .mode_q(mode), .st(status)
);

// File: tb/nor_cmd_flash_test.sv
module nor_cmd_flash_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [15:0] rdata;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;
  logic [15:0] model [32];
  logic [15:0] v;
  logic [7:0]  exp_st;

  always #4 clk = ~clk;

  nor_cmd_flash uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr(wr), .rd(rd), .rdata(rdata)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [15:0] r);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    r = rdata;
  endtask

  function automatic logic [15:0] pat(input int w);
    return 16'((w * 16'h1357 + 16'h2468) & 16'hFFFF);
  endfunction

  function automatic logic [15:0] exp_q(input int idx);
    if (idx >= 64) return 16'h0000;
    case (idx)
      16: return 16'h0051;
      17: return 16'h0052;
      18: return 16'h0059;
      19: return 16'h0001;
      39: return 16'h0006;
      44: return 16'h0001;
      45: return 16'h0003;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic sweep(input string tag);
    for (int w = 0; w < 32; w++) begin
      do_rd(8'(w * 2), v);
      check(tag, v, model[w]);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    for (int w = 0; w < 32; w++) model[w] = 16'hFFFF;
    exp_st = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset contents and status
    sweep("R1 reset array");
    do_wr(8'h00, 16'h0070);
    do_rd(8'h00, v); check("R1 reset status", v, 16'h0000);
    // R3: 0xFF back to array
    do_wr(8'h00, 16'h00FF);
    do_rd(8'h02, v); check("R3 back to array", v, 16'hFFFF);

    // R5 / R13: program every sector with one buffered sequence each
    for (int s = 0; s < 4; s++) begin
      do_wr(8'(s * 16), 16'h00E8);
      do_rd(8'(s * 16), v); check("R13 status in count wait", v, 16'(exp_st));
      do_wr(8'(s * 16), 16'h0007);
      for (int k = 0; k < 8; k++) begin
        do_wr(8'((s * 8 + k) * 2), pat(s * 8 + k));
        model[s * 8 + k] = pat(s * 8 + k);
        exp_st = 8'h80;
        if (k == 3) begin
          do_rd(8'h00, v); check("R13 status in data phase", v, 16'h0080);
        end
      end
      do_wr(8'(s * 16), 16'h00D0);
    end
    sweep("R5 programmed array");
    do_wr(8'h00, 16'h0070);
    do_rd(8'h00, v); check("R5 ready after program", v, 16'h0080);
    do_wr(8'h00, 16'h00FF);

    // R6: count 0 means one data word, then confirm slot not stored
    do_wr(8'h06, 16'h00E8);
    do_wr(8'h06, 16'h0000);
    do_wr(8'h06, 16'hAAAA); model[3] = 16'hAAAA;
    do_wr(8'h08, 16'h1234);
    do_rd(8'h06, v); check("R6 single data word", v, 16'hAAAA);
    do_rd(8'h08, v); check("R6 confirm slot not stored", v, model[4]);

    // R4: clear status
    do_wr(8'h00, 16'h0050);
    do_rd(8'h0A, v); check("R4 array mode after clear", v, model[5]);
    do_wr(8'h00, 16'h0070);
    do_rd(8'h00, v); check("R4 status cleared", v, 16'h0000);
    do_wr(8'h00, 16'h00FF);

    // R7 / R12: erase sector 2 and inject a write while busy
    do_wr(8'h20, 16'h0020);
    do_rd(8'h00, v); check("R13 status in erase wait", v, 16'h0000);
    do_wr(8'h26, 16'h00D0);
    do_rd(8'h00, v); check("R7 busy during erase", v, 16'h0000);
    do_wr(8'h00, 16'h00FF);
    repeat (12) @(negedge clk);
    do_rd(8'h00, v); check("R12 write ignored, R7 ready in status mode", v, 16'h0080);
    for (int w = 16; w < 24; w++) model[w] = 16'hFFFF;
    do_wr(8'h00, 16'h00FF);
    sweep("R7 erased sector only");

    // R8: aborted erase sequences
    do_wr(8'h02, 16'h0020);
    do_wr(8'h02, 16'h0055);
    do_rd(8'h02, v); check("R8 abort by other code", v, model[1]);
    do_wr(8'h32, 16'h0020);
    do_wr(8'h32, 16'h00FF);
    do_rd(8'h32, v); check("R8 abort by 0xFF", v, model[25]);

    // R9: lock sequences
    do_wr(8'h00, 16'h0050);
    do_wr(8'h00, 16'h0060);
    do_rd(8'h00, v); check("R13 status in lock wait", v, 16'h0000);
    do_wr(8'h00, 16'h0001);
    do_rd(8'h04, v); check("R9 array after lock", v, model[2]);
    do_wr(8'h00, 16'h0070);
    do_rd(8'h00, v); check("R9 ready after 0x01", v, 16'h0080);
    do_wr(8'h00, 16'h0050);
    do_wr(8'h00, 16'h0060);
    do_wr(8'h00, 16'h00D0);
    do_wr(8'h00, 16'h0070);
    do_rd(8'h00, v); check("R9 ready after 0xD0", v, 16'h0080);
    do_wr(8'h00, 16'h0050);
    do_wr(8'h00, 16'h0060);
    do_wr(8'h00, 16'h0033);
    do_rd(8'h04, v); check("R9 array after bad code", v, model[2]);
    do_wr(8'h00, 16'h0070);
    do_rd(8'h00, v); check("R9 status unchanged after bad code", v, 16'h0000);
    do_wr(8'h00, 16'h00FF);

    // R10: full query window sweep
    do_wr(8'h00, 16'h0098);
    for (int i = 0; i < 128; i++) begin
      do_rd(8'(i * 2), v); check("R10 query byte", v, exp_q(i));
    end
    do_wr(8'h00, 16'h0070);
    do_rd(8'h20, v); check("R10 other write ignored in query", v, 16'h0051);
    do_wr(8'h00, 16'h00FF);
    do_rd(8'h20, v); check("R10 0xFF leaves query", v, model[16]);

    // R11: unknown codes
    do_wr(8'h00, 16'h0042);
    do_rd(8'h0C, v); check("R11 unknown from array", v, model[6]);
    do_wr(8'h00, 16'h0070);
    do_wr(8'h00, 16'h00A5);
    do_rd(8'h0C, v); check("R11 unknown from status", v, model[6]);

    // R2: rdata holds without a read strobe
    addr = 8'h3E;
    repeat (3) @(negedge clk);
    check("R2 rdata holds", rdata, model[6]);

    done = 1'b1;
    finish_run();
  end
endmodule